// File: doc/BRIEF.md
# Half-Duplex Transaction Responder

This block is the answering side of a single-wire, single-initiator byte link. It waits for a transaction to open and treats the first good byte as the transaction index. It then looks up two byte counts for that index in an external descriptor table. The first count is how many bytes the initiator will push and the second is how many bytes the block must push back. Before any payload moves, the block answers with a handshake byte, which is the index with its three low bits inverted.

Inbound payload bytes leave through a write port, tagged with the index and the byte offset. Outbound bytes are fetched through a combinational read port tagged the same way. A phase whose count is zero is skipped.

Every transaction ends by recording an outcome for its index, either accepted or data error. A host reads an outcome and clears it in one operation. The byte-level physical layer, echo suppression, payload storage and the descriptor table all sit outside the block.

Top module: `txn_responder`

## Requirements
- R1: While idle, a byte presented with `rx_err` low is taken as the transaction index. A byte presented with `rx_err` high while idle is ignored and gets no answer.
- R2: The cycle after an index below `NUM_TXN` is taken, `tx_valid` is high with `tx_data` equal to the index XOR 8'h07. This holds until a cycle with `tx_ready` high.
- R3: After the handshake, exactly `desc_in_len` bytes are written at `wr_off` 0, 1, 2 and so on under `wr_idx` = index. Then exactly `desc_out_len` bytes are sent from `rd_off` 0, 1, 2 and so on. A phase with a zero count is skipped, and writing and sending never share a cycle.
- R4: When the last phase finishes, or at the handshake if both counts are zero, the status of that index becomes 4'h8 (accepted).
- R5: A byte with `rx_err` high during the receive phase is not written. The block sets the index status to 4'h2 (data error) and returns to idle.
- R6: A cycle with `st_rd_en` high puts the status of `st_rd_idx` on `st_rd_data` after the next clock edge and clears that status to 4'h0. Status values are only 4'h0, 4'h2 or 4'h8.
- R7: If a read-and-clear and an outcome post address the same index in the same cycle, the read returns the old value and the posted value is kept.
- R8: An index byte of `NUM_TXN` or more is not answered, and the block stays idle.
- R9: After `TIMEOUT_CYC` consecutive cycles inside a transaction with no byte moved, the block sets the index status to 4'h2 and returns to idle.
- R10: After reset, `tx_valid` and `wr_en` are low and every status reads 4'h0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| rx_err | input | 1 | Received byte is corrupted |
| tx_valid | output | 1 | Byte offered for transmission |
| tx_data | output | 8 | Byte to transmit |
| tx_ready | input | 1 | Transmitter takes the offered byte this cycle |
| desc_sel | output | IDX_W | Descriptor entry being looked up |
| desc_in_len | input | LEN_W | Bytes the initiator sends for the selected entry |
| desc_out_len | input | LEN_W | Bytes the block returns for the selected entry |
| wr_en | output | 1 | Inbound payload byte write strobe |
| wr_idx | output | IDX_W | Transaction index of the written byte |
| wr_off | output | LEN_W | Byte offset of the written byte |
| wr_data | output | 8 | Written byte |
| rd_idx | output | IDX_W | Transaction index of the outbound byte |
| rd_off | output | LEN_W | Byte offset of the outbound byte |
| rd_data | input | 8 | Outbound byte, combinational from the read address |
| st_rd_en | input | 1 | Read and clear one status entry |
| st_rd_idx | input | IDX_W | Status entry to read |
| st_rd_data | output | 4 | Status returned by the last read |

## Verification
The host read-and-clear and the transaction outcome post can land on the same status entry in the same clock cycle. The bench provokes this directly. It first seeds index 0 with a data error, then runs a one-byte receive transaction and drives the final payload byte and a read of index 0 on the same falling edge. The read must return the seeded 4'h2, and a follow-up read must return 4'h8. This shows the post took priority over the clear.

// File: rtl/txn_pkg.sv
// Package: shared state encoding, status codes and handshake mask for the
// transaction responder. Assumes 4-bit status words.
package txn_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACK  = 2'd1,
        ST_RECV = 2'd2,
        ST_SEND = 2'd3
    } txn_state_e;

    localparam logic [3:0] STAT_NONE = 4'h0;
    localparam logic [3:0] STAT_ERR  = 4'h2;
    localparam logic [3:0] STAT_OK   = 4'h8;
    localparam logic [7:0] HS_MASK   = 8'h07;
endpackage

// File: rtl/txn_status_regs.sv
// Module: per-index outcome registers with host read-and-clear.
// An outcome post wins over a clear to the same entry in the same cycle;
// the read still returns the value held before that edge.
// Assumes NUM_TXN >= 2.
module txn_status_regs #(
    parameter int NUM_TXN = 4,
    localparam int IDX_W  = $clog2(NUM_TXN)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 post_en,
    input  logic [IDX_W-1:0]     post_idx,
    input  logic [3:0]           post_code,
    input  logic                 rd_en,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [3:0]           rd_data,
    output logic [NUM_TXN*4-1:0] stat_flat
);
    logic [3:0] stat_q [NUM_TXN];

    for (genvar g = 0; g < NUM_TXN; g++) begin : g_entry
        // Hold one outcome; a post has priority over a clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stat_q[g] <= txn_pkg::STAT_NONE;
            else if (post_en && post_idx == IDX_W'(g))
                stat_q[g] <= post_code;
            else if (rd_en && rd_idx == IDX_W'(g))
                stat_q[g] <= txn_pkg::STAT_NONE;
        end
        assign stat_flat[g*4 +: 4] = stat_q[g];
    end

    // Capture the addressed entry for the host.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= txn_pkg::STAT_NONE;
        else if (rd_en)
            rd_data <= (int'(rd_idx) < NUM_TXN) ? stat_q[rd_idx] : txn_pkg::STAT_NONE;
    end
endmodule

// File: rtl/txn_gap_timer.sv
// Module: counts cycles without byte progress while a transaction is open.
// expired pulses on the LIMIT-th consecutive stalled cycle.
// Assumes LIMIT >= 2.
module txn_gap_timer #(
    parameter int LIMIT  = 64,
    localparam int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic kick,
    output logic expired
);
    logic [CNT_W-1:0] cnt_q;

    // Restart on progress or when no transaction is open, else count.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || kick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = run && !kick && (cnt_q == CNT_W'(LIMIT - 1));
endmodule

// File: rtl/txn_responder.sv
// Module: target-side transaction sequencer for a half-duplex byte link.
// Takes an index byte, answers index ^ 7, receives then sends the
// per-index byte counts, and posts an outcome per index.
// Assumes the link layer removes the echo of its own transmitted bytes,
// and that desc_* and rd_data are combinational from their selects.
module txn_responder #(
    parameter int NUM_TXN     = 4,
    parameter int LEN_W       = 4,
    parameter int TIMEOUT_CYC = 64,
    localparam int IDX_W      = $clog2(NUM_TXN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             rx_err,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    input  logic             tx_ready,
    output logic [IDX_W-1:0] desc_sel,
    input  logic [LEN_W-1:0] desc_in_len,
    input  logic [LEN_W-1:0] desc_out_len,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [LEN_W-1:0] wr_off,
    output logic [7:0]       wr_data,
    output logic [IDX_W-1:0] rd_idx,
    output logic [LEN_W-1:0] rd_off,
    input  logic [7:0]       rd_data,
    input  logic             st_rd_en,
    input  logic [IDX_W-1:0] st_rd_idx,
    output logic [3:0]       st_rd_data
);
    import txn_pkg::*;

    txn_state_e       state_q, state_d;
    logic [IDX_W-1:0] cur_idx_q;
    logic [LEN_W-1:0] cnt_q, in_len_q, out_len_q;
    logic             post_en, kick, expired, cnt_clr, cnt_inc, ld_len;
    logic [3:0]       post_code;
    logic [NUM_TXN*4-1:0] stat_flat;

    wire idx_ok  = ({24'd0, rx_data} < 32'(NUM_TXN));
    wire tx_fire = tx_valid && tx_ready;

    // Next-state, output and outcome decode for the sequencer.
    always_comb begin
        state_d   = state_q;
        post_en   = 1'b0;
        post_code = STAT_OK;
        tx_valid  = 1'b0;
        tx_data   = 8'h00;
        wr_en     = 1'b0;
        kick      = 1'b0;
        cnt_clr   = 1'b0;
        cnt_inc   = 1'b0;
        ld_len    = 1'b0;
        unique case (state_q)
            ST_IDLE: if (rx_valid && !rx_err && idx_ok) state_d = ST_ACK;
            ST_ACK: begin
                tx_valid = 1'b1;
                tx_data  = 8'(cur_idx_q) ^ HS_MASK;
                if (tx_fire) begin
                    kick = 1'b1; cnt_clr = 1'b1; ld_len = 1'b1;
                    if (desc_in_len != '0)       state_d = ST_RECV;
                    else if (desc_out_len != '0) state_d = ST_SEND;
                    else begin state_d = ST_IDLE; post_en = 1'b1; end
                end
            end
            ST_RECV: if (rx_valid) begin
                kick = 1'b1;
                if (rx_err) begin
                    state_d = ST_IDLE; post_en = 1'b1; post_code = STAT_ERR;
                end else begin
                    wr_en = 1'b1;
                    if (cnt_q == in_len_q - 1'b1) begin
                        cnt_clr = 1'b1;
                        if (out_len_q != '0) state_d = ST_SEND;
                        else begin state_d = ST_IDLE; post_en = 1'b1; end
                    end else cnt_inc = 1'b1;
                end
            end
            ST_SEND: begin
                tx_valid = 1'b1;
                tx_data  = rd_data;
                if (tx_fire) begin
                    kick = 1'b1;
                    if (cnt_q == out_len_q - 1'b1) begin
                        state_d = ST_IDLE; post_en = 1'b1;
                    end else cnt_inc = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (expired) begin
            state_d = ST_IDLE; post_en = 1'b1; post_code = STAT_ERR;
        end
    end

    // Sequencer registers: state, index, byte counter, latched lengths.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cur_idx_q <= '0;
            cnt_q     <= '0;
            in_len_q  <= '0;
            out_len_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && rx_valid && !rx_err && idx_ok)
                cur_idx_q <= rx_data[IDX_W-1:0];
            if (cnt_clr)      cnt_q <= '0;
            else if (cnt_inc) cnt_q <= cnt_q + 1'b1;
            if (ld_len) begin
                in_len_q  <= desc_in_len;
                out_len_q <= desc_out_len;
            end
        end
    end

    assign desc_sel = cur_idx_q;
    assign wr_idx   = cur_idx_q;
    assign wr_off   = cnt_q;
    assign wr_data  = rx_data;
    assign rd_idx   = cur_idx_q;
    assign rd_off   = cnt_q;

    txn_gap_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q != ST_IDLE),
        .kick    (kick),
        .expired (expired)
    );

    txn_status_regs #(.NUM_TXN(NUM_TXN)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .post_en   (post_en),
        .post_idx  (cur_idx_q),
        .post_code (post_code),
        .rd_en     (st_rd_en),
        .rd_idx    (st_rd_idx),
        .rd_data   (st_rd_data),
        .stat_flat (stat_flat)
    );
endmodule

// File: rtl/txn_responder_chk.sv
// Module: property checker for txn_responder, attached by bind below.
// Observes ports plus the sequencer state, outcome post and status vector.
module txn_responder_chk #(
    parameter int NUM_TXN = 4,
    localparam int IDX_W  = $clog2(NUM_TXN)
) (
    input logic                 clk,
    input logic                 rst_n,
    input txn_pkg::txn_state_e  state_q,
    input logic                 rx_valid,
    input logic [7:0]           rx_data,
    input logic                 rx_err,
    input logic                 tx_valid,
    input logic [7:0]           tx_data,
    input logic                 wr_en,
    input logic                 st_rd_en,
    input logic [IDX_W-1:0]     st_rd_idx,
    input logic [3:0]           st_rd_data,
    input logic                 post_en,
    input logic [IDX_W-1:0]     cur_idx_q,
    input logic [3:0]           post_code,
    input logic [NUM_TXN*4-1:0] stat_flat
);
    import txn_pkg::*;

    logic [IDX_W-1:0] last_rd_idx;
    // Remember the status index addressed one cycle ago.
    always_ff @(posedge clk) last_rd_idx <= st_rd_idx;

    wire in_range = ({24'd0, rx_data} < 32'(NUM_TXN));
    wire collide  = st_rd_en && post_en && (cur_idx_q == st_rd_idx);

    p_handshake_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && rx_valid && !rx_err && in_range)
        |=> (tx_valid && tx_data == ($past(rx_data) ^ HS_MASK)));

    p_idle_err_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && rx_valid && rx_err) |=> (state_q == ST_IDLE && !tx_valid));

    p_out_of_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && rx_valid && !in_range) |=> (state_q == ST_IDLE && !tx_valid));

    p_half_duplex_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !tx_valid);

    p_recv_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECV && rx_valid && rx_err) |-> !wr_en ##1 (state_q == ST_IDLE));

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_rd_en && !collide) |=> (stat_flat[{last_rd_idx, 2'b00} +: 4] == STAT_NONE));

    p_codes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_rd_data == STAT_NONE || st_rd_data == STAT_ERR || st_rd_data == STAT_OK));

    p_post_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        collide |=> (stat_flat[{last_rd_idx, 2'b00} +: 4] == $past(post_code)));
endmodule

bind txn_responder txn_responder_chk #(.NUM_TXN(NUM_TXN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_q    (state_q),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_err     (rx_err),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .wr_en      (wr_en),
    .st_rd_en   (st_rd_en),
    .st_rd_idx  (st_rd_idx),
    .st_rd_data (st_rd_data),
    .post_en    (post_en),
    .cur_idx_q  (cur_idx_q),
    .post_code  (post_code),
    .stat_flat  (stat_flat)
);

// File: tb/test_txn_responder.sv
module test_txn_responder;
    localparam int CLK_PERIOD = 10;
    localparam int NUM  = 4;
    localparam int LW   = 4;
    localparam int TMO  = 64;
    localparam int IW   = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic rx_valid = 1'b0, rx_err = 1'b0, tx_ready = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic tx_valid, wr_en;
    logic [7:0] tx_data, wr_data, rd_data;
    logic [IW-1:0] desc_sel, wr_idx, rd_idx;
    logic [LW-1:0] desc_in_len, desc_out_len, wr_off, rd_off;
    logic st_rd_en = 1'b0;
    logic [IW-1:0] st_rd_idx = '0;
    logic [3:0] st_rd_data;

    logic [LW-1:0] tb_in_len  [NUM];
    logic [LW-1:0] tb_out_len [NUM];
    logic [7:0]    tb_src     [NUM][16];

    int n_tests = 0, n_fail = 0;
    bit finished = 1'b0;
    logic cap_we;
    logic [IW-1:0] cap_wi;
    logic [LW-1:0] cap_wo;
    logic [7:0] cap_wd;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign desc_in_len  = tb_in_len[desc_sel];
    assign desc_out_len = tb_out_len[desc_sel];
    assign rd_data      = tb_src[rd_idx][rd_off];

    txn_responder #(.NUM_TXN(NUM), .LEN_W(LW), .TIMEOUT_CYC(TMO)) i_txn_responder (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .desc_sel(desc_sel), .desc_in_len(desc_in_len), .desc_out_len(desc_out_len),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_off(wr_off), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_off(rd_off), .rd_data(rd_data),
        .st_rd_en(st_rd_en), .st_rd_idx(st_rd_idx), .st_rd_data(st_rd_data)
    );

    function automatic logic [7:0] exp_hs(input int idx);
        return 8'(idx) ^ 8'h07;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Present one received byte for one cycle; capture the write port.
    task automatic send_rx(input logic [7:0] b, input logic err);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b; rx_err = err;
        #1;
        cap_we = wr_en; cap_wi = wr_idx; cap_wo = wr_off; cap_wd = wr_data;
        @(posedge clk); #1;
        rx_valid = 1'b0; rx_err = 1'b0;
    endtask

    // Accept one transmitted byte with random backpressure.
    task automatic get_tx(output logic [7:0] b, output bit got);
        got = 1'b0; b = 8'h00;
        for (int k = 0; k < 40 && !got; k++) begin
            @(negedge clk);
            tx_ready = ($urandom % 4) != 0;
            #1;
            if (tx_valid && tx_ready) begin b = tx_data; got = 1'b1; end
        end
        @(posedge clk); #1;
        tx_ready = 1'b0;
    endtask

    task automatic rd_stat(input int idx, output logic [3:0] v);
        @(negedge clk);
        st_rd_en = 1'b1; st_rd_idx = IW'(idx);
        @(posedge clk); #1;
        st_rd_en = 1'b0;
        v = st_rd_data;
    endtask

    // Full transaction with checks on handshake, payload and outcome.
    task automatic run_txn(input int idx);
        logic [7:0] b, p;
        logic [3:0] s;
        bit got;
        send_rx(8'(idx), 1'b0);
        get_tx(b, got);
        check(got && b == exp_hs(idx), "R2 handshake", b, exp_hs(idx));
        for (int i = 0; i < int'(tb_in_len[idx]); i++) begin
            p = 8'($urandom);
            send_rx(p, 1'b0);
            check(cap_we && cap_wi == IW'(idx) && cap_wo == LW'(i) && cap_wd == p,
                  "R3 inbound write", {cap_we, cap_wo, cap_wd}, {1'b1, LW'(i), p});
        end
        for (int i = 0; i < int'(tb_out_len[idx]); i++) begin
            get_tx(b, got);
            check(got && b == tb_src[idx][i], "R3 outbound byte", b, tb_src[idx][i]);
        end
        rd_stat(idx, s);
        check(s == 4'h8, "R4 accepted status", s, 8);
        if ($urandom % 2) begin
            rd_stat(idx, s);
            check(s == 4'h0, "R6 cleared after read", s, 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        logic [3:0] s;
        bit got;
        int seed;
        seed = int'($urandom(32'd1234));
        for (int i = 0; i < NUM; i++) begin
            tb_in_len[i] = '0; tb_out_len[i] = '0;
            for (int j = 0; j < 16; j++) tb_src[i][j] = 8'($urandom);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        #1;
        check(!tx_valid && !wr_en, "R10 outputs idle", {tx_valid, wr_en}, 0);
        for (int i = 0; i < NUM; i++) begin
            rd_stat(i, s);
            check(s == 4'h0, "R10 status cleared", s, 0);
        end

        // R3/R4: both phases zero length
        tb_in_len[1] = 0; tb_out_len[1] = 0;
        run_txn(1);

        // R8: out-of-range index gets no answer
        send_rx(8'h09, 1'b0);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); #1;
            check(!tx_valid, "R8 no reply to bad index", tx_valid, 0);
        end
        // R1: errored byte in idle ignored
        send_rx(8'h02, 1'b1);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); #1;
            check(!tx_valid, "R1 errored idle byte ignored", tx_valid, 0);
        end

        // R5: corrupted byte during receive
        tb_in_len[2] = 3; tb_out_len[2] = 2;
        send_rx(8'h02, 1'b0);
        get_tx(b, got);
        check(got && b == exp_hs(2), "R2 handshake idx2", b, exp_hs(2));
        send_rx(8'h5a, 1'b0);
        check(cap_we, "R3 first byte written", cap_we, 1);
        send_rx(8'ha5, 1'b1);
        check(!cap_we, "R5 corrupted byte not written", cap_we, 0);
        @(negedge clk); #1;
        check(!tx_valid, "R5 back to idle", tx_valid, 0);
        rd_stat(2, s);
        check(s == 4'h2, "R5 data error status", s, 2);

        // R9: inter-byte timeout
        tb_in_len[3] = 2; tb_out_len[3] = 1;
        send_rx(8'h03, 1'b0);
        get_tx(b, got);
        check(got && b == exp_hs(3), "R2 handshake idx3", b, exp_hs(3));
        repeat (TMO + 6) @(negedge clk);
        #1;
        check(!tx_valid, "R9 idle after timeout", tx_valid, 0);
        rd_stat(3, s);
        check(s == 4'h2, "R9 timeout error status", s, 2);
        send_rx(8'h01, 1'b0);
        get_tx(b, got);
        check(got && b == exp_hs(1), "R9 new transaction after abort", b, exp_hs(1));
        rd_stat(1, s);
        check(s == 4'h8, "R4 accepted after abort", s, 8);

        // R7: post and read-and-clear on the same index in the same cycle
        tb_in_len[0] = 1; tb_out_len[0] = 0;
        send_rx(8'h00, 1'b0);
        get_tx(b, got);
        send_rx(8'h11, 1'b1);
        send_rx(8'h00, 1'b0);
        get_tx(b, got);
        check(got && b == exp_hs(0), "R2 handshake idx0", b, exp_hs(0));
        @(negedge clk);
        rx_valid = 1'b1; rx_data = 8'h3c; rx_err = 1'b0;
        st_rd_en = 1'b1; st_rd_idx = '0;
        @(posedge clk); #1;
        rx_valid = 1'b0; st_rd_en = 1'b0;
        check(st_rd_data == 4'h2, "R7 read returns old value", st_rd_data, 2);
        rd_stat(0, s);
        check(s == 4'h8, "R7 post kept over clear", s, 8);

        // Random transactions
        for (int t = 0; t < 40; t++) begin
            int idx;
            idx = int'($urandom % NUM);
            tb_in_len[idx]  = LW'($urandom % 7);
            tb_out_len[idx] = LW'($urandom % 7);
            run_txn(idx);
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule